// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block is the hazard-control logic for a five-stage integer pipeline with the stages fetch, decode, execute, memory and write-back. Operands are read from the register file in decode, and results are written back in write-back. In every cycle the block looks at the source registers of the instruction in execute and of the instruction in decode. It also looks at the destination, write enable and load flag of the instruction in execute, and at the destination and write enable held in the two later pipeline registers (the execute/memory register and the memory/write-back register). From these it picks where each ALU operand comes from.

The block raises a stall when a load in execute writes a register that the instruction in decode needs. The pipeline then holds the program counter and the fetch/decode register, and loads a bubble into the decode/execute register. A bubble clears the write enable and the memory enables of that register. The block also raises flush signals when a branch redirects the program. The parameter `RESOLVE_IN_EX` selects the stage where branches resolve. If they resolve in execute, two younger instructions are cancelled. If they resolve in decode, one is cancelled.

Every output is combinational on the current inputs. The clock and reset feed only the embedded property checks.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the execute/memory stage is eligible and its destination equals an execute-stage source register, that operand's select is 2'b10 (take the execute/memory value).
- R2: When only the memory/write-back stage is eligible and matches, the select is 2'b01. When no stage matches, it is 2'b00 (register file value). The code 2'b11 never appears.
- R3: When both later stages are eligible and match the same source register, the execute/memory stage wins and the select is 2'b10.
- R4: A stage is eligible as a source only when its write enable is 1 and its destination is not register 0. A source register of 0 always gets select 2'b00.
- R5: Operand A and operand B are selected independently: each select depends only on its own source register number.
- R6: `stall` is 1 when all of these hold: the execute instruction is a load, its write enable is set, its destination is non-zero, and that destination equals a decode source whose use flag is set. `stall` is 0 when the matching source's use flag is clear or the execute instruction is not a load.
- R7: With `RESOLVE_IN_EX`=1, `br_taken` sets both `flush_if` and `flush_id` in the same cycle and forces `stall` to 0.
- R8: With `RESOLVE_IN_EX`=0, `br_taken` sets only `flush_if`, and `flush_id` stays 0. If `stall` is set in that cycle, the stall takes priority and `flush_if` stays 0.
- R9: Drive a pipeline with R1=5, R2=1, R3=3, R4=5. Run the program: add R1=R2+R3; shift R4=R2<<R1; compare R3=(R4==R1). With the block's selects, the pipeline ends with R1=4, R4=16 and R3=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| ex_rs_a | input | AW | Execute-stage source register for operand A |
| ex_rs_b | input | AW | Execute-stage source register for operand B |
| id_rs_a | input | AW | Decode-stage first source register |
| id_rs_b | input | AW | Decode-stage second source register |
| id_use_a | input | 1 | Decode instruction reads `id_rs_a` |
| id_use_b | input | 1 | Decode instruction reads `id_rs_b` |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_wen | input | 1 | Write enable held in the execute/memory register |
| wb_rd | input | AW | Destination held in the memory/write-back register |
| wb_wen | input | 1 | Write enable held in the memory/write-back register |
| br_taken | input | 1 | A branch in the resolving stage redirects the program |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 write-back, 10 execute/memory |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and fetch/decode, insert a bubble into decode/execute |
| flush_if | output | 1 | Cancel the instruction in fetch |
| flush_id | output | 1 | Cancel the instruction in decode |

## Verification
Every result is due in the same cycle as the inputs that cause it, because no register lies between inputs and outputs. The bench changes inputs one time unit after a rising edge and samples at the next falling edge. It compares both selects, the stall and the two flushes against a behavioural model, once per cycle. The program check runs a bench-side pipeline in which a result reaches the execute/memory register one edge after execute and the write-back register one edge later. The selects are sampled while the consumer is in execute, and the register values are read only after the last write-back edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } src_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rs,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   output logic [1:0]    sel
);
   import hz_pkg::*;

   logic mem_ok, wb_ok, mem_hit, wb_hit;
   src_sel_e pick;

   assign mem_ok  = mem_wen && (mem_rd != '0);
   assign wb_ok   = wb_wen  && (wb_rd  != '0);
   assign mem_hit = mem_ok && (mem_rd == rs);
   assign wb_hit  = wb_ok  && (wb_rd  == rs);

   always_comb begin
      if (mem_hit)     pick = SRC_MEM;
      else if (wb_hit) pick = SRC_WB;
      else             pick = SRC_RF;
   end

   assign sel = pick;

   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sel != 2'b11); // R2
   AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && mem_rd == rs && rs != '0) |-> sel == 2'b10); // R3
   AST_ZERO_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
      (rs == '0) |-> sel == 2'b00); // R4
   AST_WB_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b01) |-> (wb_wen && wb_rd == rs)); // R2
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
   parameter int AW   = 5,
   parameter int NSRC = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW-1:0]             ex_rd,
   input  logic                      ex_wen,
   input  logic                      ex_load,
   input  logic [NSRC-1:0][AW-1:0]   id_rs,
   input  logic [NSRC-1:0]           id_use,
   output logic                      hit
);
   logic             producer;
   logic [NSRC-1:0]  match;

   assign producer = ex_load && ex_wen && (ex_rd != '0);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign match[s] = id_use[s] && (id_rs[s] == ex_rd);
   end

   assign hit = producer && (|match);

   AST_HIT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (ex_load && ex_wen)); // R6
   AST_UNUSED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (id_use == '0) |-> !hit); // R6
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect #(
   parameter bit RESOLVE_IN_EX = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic br_taken,
   input  logic lu_hit,
   output logic stall,
   output logic flush_if,
   output logic flush_id
);
   if (RESOLVE_IN_EX) begin : g_ex
      assign stall    = lu_hit && !br_taken;
      assign flush_if = br_taken;
      assign flush_id = br_taken;

      AST_EX_FLUSH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
         br_taken |-> (flush_if && flush_id && !stall)); // R7
   end else begin : g_id
      assign stall    = lu_hit;
      assign flush_if = br_taken && !lu_hit;
      assign flush_id = 1'b0;

      AST_ID_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         !flush_id && !(stall && flush_if)); // R8
   end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
   parameter int AW            = 5,
   parameter bit RESOLVE_IN_EX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ex_rs_a,
   input  logic [AW-1:0] ex_rs_b,
   input  logic [AW-1:0] id_rs_a,
   input  logic [AW-1:0] id_rs_b,
   input  logic          id_use_a,
   input  logic          id_use_b,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic          ex_load,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   input  logic          br_taken,
   output logic [1:0]    fwd_a_sel,
   output logic [1:0]    fwd_b_sel,
   output logic          stall,
   output logic          flush_if,
   output logic          flush_id
);
   localparam int NOPS = 2;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("pipe_hazard_unit: AW must be between 1 and 8");
   end

   logic [NOPS-1:0][AW-1:0] ex_rs_v;
   logic [NOPS-1:0][AW-1:0] id_rs_v;
   logic [NOPS-1:0][1:0]    sel_v;
   logic [NOPS-1:0]         id_use_v;
   logic                    lu_hit;

   assign ex_rs_v  = {ex_rs_b, ex_rs_a};
   assign id_rs_v  = {id_rs_b, id_rs_a};
   assign id_use_v = {id_use_b, id_use_a};

   for (genvar g = 0; g < NOPS; g++) begin : g_op
      hz_fwd_pick #(.AW(AW)) u_pick (
         .clk     (clk),
         .rst_n   (rst_n),
         .rs      (ex_rs_v[g]),
         .mem_rd  (mem_rd),
         .mem_wen (mem_wen),
         .wb_rd   (wb_rd),
         .wb_wen  (wb_wen),
         .sel     (sel_v[g])
      );
   end

   assign fwd_a_sel = sel_v[0];
   assign fwd_b_sel = sel_v[1];

   hz_loaduse #(.AW(AW), .NSRC(NOPS)) u_lu (
      .clk     (clk),
      .rst_n   (rst_n),
      .ex_rd   (ex_rd),
      .ex_wen  (ex_wen),
      .ex_load (ex_load),
      .id_rs   (id_rs_v),
      .id_use  (id_use_v),
      .hit     (lu_hit)
   );

   hz_redirect #(.RESOLVE_IN_EX(RESOLVE_IN_EX)) u_redir (
      .clk      (clk),
      .rst_n    (rst_n),
      .br_taken (br_taken),
      .lu_hit   (lu_hit),
      .stall    (stall),
      .flush_if (flush_if),
      .flush_id (flush_id)
   );

   AST_NO_MEM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wen |-> (fwd_a_sel != 2'b10 && fwd_b_sel != 2'b10)); // R4
   AST_OPS_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rs_a == ex_rs_b) |-> (fwd_a_sel == fwd_b_sel)); // R5
   AST_STALL_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ex_load); // R6
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] ex_rs_a, ex_rs_b, id_rs_a, id_rs_b, ex_rd, mem_rd, wb_rd;
   logic id_use_a, id_use_b, ex_wen, ex_load, mem_wen, wb_wen, br_taken;
   logic [1:0] a_sel, b_sel, a_sel2, b_sel2;
   logic stall, fl_if, fl_id, stall2, fl_if2, fl_id2;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_hazard_unit #(.AW(AW), .RESOLVE_IN_EX(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
      .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd),
      .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen), .br_taken(br_taken),
      .fwd_a_sel(a_sel), .fwd_b_sel(b_sel), .stall(stall),
      .flush_if(fl_if), .flush_id(fl_id));

   pipe_hazard_unit #(.AW(AW), .RESOLVE_IN_EX(1'b0)) u_dut_id (
      .clk(clk), .rst_n(rst_n), .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
      .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd),
      .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen), .br_taken(br_taken),
      .fwd_a_sel(a_sel2), .fwd_b_sel(b_sel2), .stall(stall2),
      .flush_if(fl_if2), .flush_id(fl_id2));

   function automatic int want_sel(int rs);
      if (mem_wen && mem_rd != 0 && int'(mem_rd) == rs) return 2;
      if (wb_wen && wb_rd != 0 && int'(wb_rd) == rs) return 1;
      return 0;
   endfunction

   function automatic bit want_lu();
      if (!(ex_load && ex_wen) || ex_rd == 0) return 0;
      return (id_use_a && id_rs_a == ex_rd) || (id_use_b && id_rs_b == ex_rd);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      bit lu;
      lu = want_lu();
      chk({tag, " R1 R2 R3 R4 R5 sel A"}, int'(a_sel), want_sel(int'(ex_rs_a)));
      chk({tag, " R1 R2 R3 R4 R5 sel B"}, int'(b_sel), want_sel(int'(ex_rs_b)));
      chk({tag, " R6 R7 stall ex"},  int'(stall), int'(lu && !br_taken));
      chk({tag, " R7 flush_if ex"},  int'(fl_if), int'(br_taken));
      chk({tag, " R7 flush_id ex"},  int'(fl_id), int'(br_taken));
      chk({tag, " R5 sel A id"},     int'(a_sel2), want_sel(int'(ex_rs_a)));
      chk({tag, " R6 R8 stall id"},  int'(stall2), int'(lu));
      chk({tag, " R8 flush_if id"},  int'(fl_if2), int'(br_taken && !lu));
      chk({tag, " R8 flush_id id"},  int'(fl_id2), 0);
   endtask

   task automatic clear_in();
      ex_rs_a = '0; ex_rs_b = '0; id_rs_a = '0; id_rs_b = '0;
      id_use_a = 0; id_use_b = 0; ex_rd = '0; ex_wen = 0; ex_load = 0;
      mem_rd = '0; mem_wen = 0; wb_rd = '0; wb_wen = 0; br_taken = 0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic next();
      @(posedge clk);
      #1;
      clear_in();
   endtask

   // bench-side pipeline for the program check
   int rf [0:7];
   int p_op [0:2] = '{0, 1, 2};
   int p_rd [0:2] = '{1, 4, 3};
   int p_ra [0:2] = '{2, 2, 4};
   int p_rb [0:2] = '{3, 1, 1};

   initial begin
      clear_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("reset");
      chk("reset R2 sel A", int'(a_sel), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // directed: R1 forward from EX/MEM
      next(); ex_rs_a = 5'd3; mem_rd = 5'd3; mem_wen = 1; step();
      check_all("dir"); chk("R1 A from mem", int'(a_sel), 2); chk("R5 B untouched", int'(b_sel), 0);
      // R2 from WB on operand B
      next(); ex_rs_b = 5'd7; wb_rd = 5'd7; wb_wen = 1; step();
      check_all("dir"); chk("R2 B from wb", int'(b_sel), 1);
      // R3 both match
      next(); ex_rs_a = 5'd9; mem_rd = 5'd9; mem_wen = 1; wb_rd = 5'd9; wb_wen = 1; step();
      check_all("dir"); chk("R3 younger wins", int'(a_sel), 2);
      // R4 register 0 and cleared write enable
      next(); ex_rs_a = 0; mem_rd = 0; mem_wen = 1; ex_rs_b = 5'd4; wb_rd = 5'd4; wb_wen = 0; step();
      check_all("dir"); chk("R4 r0 not forwarded", int'(a_sel), 0); chk("R4 wen off", int'(b_sel), 0);
      next(); ex_rs_a = 5'd4; mem_rd = 5'd4; mem_wen = 0; wb_rd = 5'd4; wb_wen = 1; step();
      chk("R4 fall to wb", int'(a_sel), 1);
      // R5 different sources, different picks
      next(); ex_rs_a = 5'd2; ex_rs_b = 5'd6; mem_rd = 5'd6; mem_wen = 1; wb_rd = 5'd2; wb_wen = 1; step();
      chk("R5 A wb", int'(a_sel), 1); chk("R5 B mem", int'(b_sel), 2);
      // R6 load-use
      next(); ex_load = 1; ex_wen = 1; ex_rd = 5'd8; id_rs_b = 5'd8; id_use_b = 1; step();
      chk("R6 stall on use", int'(stall), 1);
      next(); ex_load = 1; ex_wen = 1; ex_rd = 5'd8; id_rs_b = 5'd8; id_use_b = 0; step();
      chk("R6 unused source", int'(stall), 0);
      next(); ex_load = 0; ex_wen = 1; ex_rd = 5'd8; id_rs_a = 5'd8; id_use_a = 1; step();
      chk("R6 not load", int'(stall), 0);
      next(); ex_load = 1; ex_wen = 1; ex_rd = 0; id_rs_a = 0; id_use_a = 1; step();
      chk("R6 r0 load", int'(stall), 0);
      // R7 / R8 branch with and without concurrent load-use
      next(); br_taken = 1; step();
      chk("R7 flush_if", int'(fl_if), 1); chk("R7 flush_id", int'(fl_id), 1);
      chk("R8 flush_if", int'(fl_if2), 1); chk("R8 flush_id", int'(fl_id2), 0);
      next(); br_taken = 1; ex_load = 1; ex_wen = 1; ex_rd = 5'd5; id_rs_a = 5'd5; id_use_a = 1; step();
      chk("R7 stall dropped", int'(stall), 0); chk("R7 flush_id", int'(fl_id), 1);
      chk("R8 stall kept", int'(stall2), 1); chk("R8 flush held", int'(fl_if2), 0);

      // random phase, registers 0..3 to force collisions
      for (int i = 0; i < 3000; i++) begin
         next();
         ex_rs_a = AW'($urandom_range(0, 3)); ex_rs_b = AW'($urandom_range(0, 3));
         id_rs_a = AW'($urandom_range(0, 3)); id_rs_b = AW'($urandom_range(0, 3));
         id_use_a = 1'($urandom); id_use_b = 1'($urandom);
         ex_rd = AW'($urandom_range(0, 3)); ex_wen = 1'($urandom); ex_load = 1'($urandom);
         mem_rd = AW'($urandom_range(0, 3)); mem_wen = 1'($urandom);
         wb_rd = AW'($urandom_range(0, 3)); wb_wen = 1'($urandom);
         br_taken = ($urandom_range(0, 7) == 0);
         step();
         check_all("rand");
      end

      // R9 program through a bench pipeline
      begin
         int id_i, ex_i, mem_i, wb_i;
         int ex_va, ex_vb, mem_res, wb_res, res, oa, ob;
         rf[0] = 0; rf[1] = 5; rf[2] = 1; rf[3] = 3; rf[4] = 5; rf[5] = 0; rf[6] = 0; rf[7] = 0;
         id_i = 0; ex_i = -1; mem_i = -1; wb_i = -1;
         ex_va = 0; ex_vb = 0; mem_res = 0; wb_res = 0;
         for (int c = 0; c < 8; c++) begin
            next();
            if (id_i >= 0) begin
               id_rs_a = AW'(p_ra[id_i]); id_rs_b = AW'(p_rb[id_i]); id_use_a = 1; id_use_b = 1;
            end
            if (ex_i >= 0) begin
               ex_rs_a = AW'(p_ra[ex_i]); ex_rs_b = AW'(p_rb[ex_i]);
               ex_rd = AW'(p_rd[ex_i]); ex_wen = 1;
            end
            if (mem_i >= 0) begin mem_rd = AW'(p_rd[mem_i]); mem_wen = 1; end
            if (wb_i >= 0) begin wb_rd = AW'(p_rd[wb_i]); wb_wen = 1; end
            step();
            res = 0;
            if (ex_i >= 0) begin
               oa = (a_sel == 2) ? mem_res : (a_sel == 1) ? wb_res : ex_va;
               ob = (b_sel == 2) ? mem_res : (b_sel == 1) ? wb_res : ex_vb;
               case (p_op[ex_i])
                  0: res = oa + ob;
                  1: res = oa << ob;
                  default: res = (oa == ob) ? 1 : 0;
               endcase
               if (ex_i == 1) chk("R9 shift B from mem", int'(b_sel), 2);
               if (ex_i == 2) begin
                  chk("R9 compare A from mem", int'(a_sel), 2);
                  chk("R9 compare B from wb", int'(b_sel), 1);
               end
            end
            @(posedge clk);
            if (wb_i >= 0) rf[p_rd[wb_i]] = wb_res;
            wb_i = mem_i; wb_res = mem_res;
            mem_i = ex_i; mem_res = res;
            ex_i = id_i;
            if (id_i >= 0) begin ex_va = rf[p_ra[id_i]]; ex_vb = rf[p_rb[id_i]]; end
            id_i = (id_i >= 0 && id_i < 2) ? id_i + 1 : -1;
         end
         chk("R9 R1 result", rf[1], 4);
         chk("R9 R4 result", rf[4], 16);
         chk("R9 R3 result", rf[3], 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule